// File: doc/BRIEF.md
# Glitch-free two-input clock switch

This block picks one of two unrelated input clocks and passes it to a single output clock. The level on `sel` chooses the source. A change of source never produces a shortened high or low phase at the output. The block first parks the output low, in step with the outgoing clock. It then holds the output low until the incoming clock has been brought in, and starts the output again on a rising edge of that clock.

Each source has an enable. That enable is synchronised on the falling edges of its own clock, and it is requested only after the enable of the other source has been seen to drop. A source that stops toggling would normally freeze its enable and leave the handoff waiting for ever. To prevent this, each source has an activity monitor running from a free-running reference clock. When a source has shown no edge for `DEAD_LIMIT` reference cycles, the monitor clears that source's enable asynchronously, and the handoff then goes ahead.

The block is specified for clocks whose frequencies differ by no more than a factor of ten, and for `sel` changing no more often than once every 250 periods of the slower clock.

Top module: `clksw_top`

## Requirements
- R1: `sel` = 0 selects `clk0` and `sel` = 1 selects `clk1`. Once a handoff has completed, `clk_out` is high exactly while the selected clock is high.
- R2: After `sel` changes, `clk_out` keeps following the old clock up to and including its second or third falling edge. After that edge it is low.
- R3: Once parked, `clk_out` stays low for two or three falling edges of the new clock. Its first rising edge afterwards coincides with a rising edge of the new clock.
- R4: No high or low phase of `clk_out` is shorter than the shorter half-period of the two input clocks. The two source enables are never on at the same time.
- R5: When the newly selected clock is absent, `clk_out` stays low. Once that clock starts toggling, `clk_out` follows it.
- R6: When the old clock stops, its enable is forced off after `DEAD_LIMIT` reference cycles without an edge, and the handoff to the live clock then completes. The stopped clock can be selected again cleanly once it has resumed.
- R7: While `rst_n` is low, `clk_out` is low. After `rst_n` is released, `clk_out` stays low until the selected clock has produced two or three falling edges, and then starts on a rising edge of that clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock for the activity monitors |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk0 | input | 1 | Source clock 0, selected when `sel` is 0 |
| clk1 | input | 1 | Source clock 1, selected when `sel` is 1 |
| sel | input | 1 | Source select level |
| clk_out | output | 1 | Switched output clock |

## Verification
The bench builds the block with `DEAD_LIMIT` = 64 and `SYNC_STAGES` = 2. With this limit, a stopped source is declared dead about 260 ns after its last edge, so the stopped-old-clock and stopped-new-clock handoffs each finish within a few microseconds of simulated time. The limit still lies well above the 19 reference cycles of the slowest clock used (76 ns), so a slow but live clock is never mistaken for a dead one. With two stages, every handoff should take exactly two falling edges on each side. This lets the bench test the 2-to-3 edge windows tightly, and it keeps the 9.5:1 frequency-ratio cases short.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;

    localparam int NUM_SRC = 2;

    typedef logic [NUM_SRC-1:0] src_vec_t;

endpackage

// File: rtl/clksw_enable_sync.sv
`timescale 1ns/1ps
// Enable synchroniser for one source: a shift chain clocked on the falling
// edge of that source, cleared asynchronously by reset or by the monitor.
module clksw_enable_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clr_n,
    input  logic req,
    output logic en
);

    typedef struct packed {
        logic [STAGES-1:0] pipe;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[STAGES-2:0], req};
    end

    always_ff @(negedge clk or negedge clr_n) begin
        if (!clr_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en = st_q.pipe[STAGES-1];

endmodule

// File: rtl/clksw_activity_mon.sv
`timescale 1ns/1ps
// Source activity monitor. A toggle flop in the monitored domain is brought
// into the reference domain, and the number of reference cycles since its
// last change is counted. The source is declared dead at LIMIT.
module clksw_activity_mon #(
    parameter int LIMIT  = 1024,
    parameter int STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic mon_clk,
    output logic dead
);

    localparam int CNT_W = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [STAGES:0]    samp;
        logic [CNT_W-1:0]   cnt;
        logic               dead;
    } mon_state_t;

    logic       tog_d, tog_q;
    mon_state_t st_d, st_q;
    logic       seen_edge;

    always_comb begin
        tog_d = ~tog_q;
    end

    always_ff @(negedge mon_clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
        end else begin
            tog_q <= tog_d;
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.samp = {st_q.samp[STAGES-1:0], tog_q};
        seen_edge = st_q.samp[STAGES] ^ st_q.samp[STAGES-1];
        if (seen_edge) begin
            st_d.cnt  = '0;
            st_d.dead = 1'b0;
        end else if (st_q.cnt == CNT_W'(LIMIT)) begin
            st_d.dead = 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dead = st_q.dead;

endmodule

// File: rtl/clksw_top.sv
`timescale 1ns/1ps
module clksw_top #(
    parameter int DEAD_LIMIT  = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic clk0,
    input  logic clk1,
    input  logic sel,
    output logic clk_out
);
    import clksw_pkg::*;

    src_vec_t clk_vec;
    src_vec_t req;
    src_vec_t en_q;
    src_vec_t dead;
    src_vec_t clr_n;

    // A source asks for its enable only while selected and while the other
    // source's enable is seen off.
    always_comb begin
        clk_vec = {clk1, clk0};
        req[0]  = ~sel & ~en_q[1];
        req[1]  =  sel & ~en_q[0];
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        clksw_activity_mon #(
            .LIMIT  (DEAD_LIMIT),
            .STAGES (SYNC_STAGES)
        ) u_mon (
            .ref_clk (ref_clk),
            .rst_n   (rst_n),
            .mon_clk (clk_vec[i]),
            .dead    (dead[i])
        );

        assign clr_n[i] = rst_n & ~dead[i];

        clksw_enable_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk   (clk_vec[i]),
            .clr_n (clr_n[i]),
            .req   (req[i]),
            .en    (en_q[i])
        );
    end

    assign clk_out = |(clk_vec & en_q);

endmodule

// File: rtl/clksw_checker.sv
`timescale 1ns/1ps
module clksw_checker (
    input logic       ref_clk,
    input logic       rst_n,
    input logic       sel,
    input logic       clk_out,
    input logic [1:0] en,
    input logic [1:0] dead
);

    AST_ENABLES_EXCLUSIVE: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !(en[0] && en[1])); // R4

    AST_EN0_RISE_SELECTED: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(en[0]) |-> !sel); // R1

    AST_EN1_RISE_SELECTED: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(en[1]) |-> sel); // R1

    AST_DEAD0_CLEARS_EN: assert property (@(posedge ref_clk) disable iff (!rst_n)
        dead[0] |-> !en[0]); // R6

    AST_DEAD1_CLEARS_EN: assert property (@(posedge ref_clk) disable iff (!rst_n)
        dead[1] |-> !en[1]); // R6

    always @(posedge ref_clk) begin
        if (!rst_n) begin
            AST_RESET_OUT_LOW: assert (!clk_out); // R7
        end
    end

endmodule

bind clksw_top clksw_checker u_chk (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .sel     (sel),
    .clk_out (clk_out),
    .en      (en_q),
    .dead    (dead)
);

// File: tb/clksw_top_bench.sv
`timescale 1ns/1ps
module clksw_top_bench;

    localparam int DEAD_LIMIT = 64;
    localparam int NROWS = 6;
    // columns: sel, clk0 half period (ns), clk1 half period (ns), half cycles checked
    localparam int VEC [NROWS][4] = '{
        '{0,  5,  7, 20},
        '{1,  5,  7, 20},
        '{1,  4, 38, 12},
        '{0,  4, 38, 40},
        '{0, 15,  6, 20},
        '{1, 15,  6, 40}
    };

    logic ref_clk = 1'b0;
    logic rst_n   = 1'b1;
    logic clk0    = 1'b0;
    logic clk1    = 1'b0;
    logic sel     = 1'b0;
    logic clk_out;

    real h0 = 5.0;
    real h1 = 7.0;
    bit  run0 = 1'b1;
    bit  run1 = 1'b1;
    int  nfall0 = 0;
    int  nfall1 = 0;

    int n_checks = 0;
    int n_fail   = 0;

    bit  mon_arm = 1'b0;
    real last_t  = 0.0;
    real min_w   = 1.0e9;

    clksw_top #(
        .DEAD_LIMIT  (DEAD_LIMIT),
        .SYNC_STAGES (2)
    ) u_clksw_top (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .clk0    (clk0),
        .clk1    (clk1),
        .sel     (sel),
        .clk_out (clk_out)
    );

    always #2 ref_clk = ~ref_clk;

    initial begin
        #0.7;
        forever begin
            if (run0) begin
                #(h0) clk0 = 1'b1;
                #(h0) clk0 = 1'b0;
                nfall0++;
            end else begin
                #1;
            end
        end
    end

    initial begin
        #1.3;
        forever begin
            if (run1) begin
                #(h1) clk1 = 1'b1;
                #(h1) clk1 = 1'b0;
                nfall1++;
            end else begin
                #1;
            end
        end
    end

    // shortest phase seen on the output outside reset
    always @(clk_out) begin
        if (mon_arm && rst_n && ($realtime - last_t) < min_w) begin
            min_w = $realtime - last_t;
        end
        last_t = $realtime;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic real half(input int s);
        return (s == 0) ? h0 : h1;
    endfunction

    function automatic int falls(input int s);
        return (s == 0) ? nfall0 : nfall1;
    endfunction

    function automatic logic clk_of(input int s);
        return (s == 0) ? clk0 : clk1;
    endfunction

    task automatic wait_rise(input int s);
        if (s == 0) @(posedge clk0); else @(posedge clk1);
    endtask

    task automatic wait_fall(input int s);
        if (s == 0) @(negedge clk0); else @(negedge clk1);
    endtask

    task automatic settle();
        #(80.0 * ((h0 > h1) ? h0 : h1));
    endtask

    task automatic check_follow(input int s, input int n, input string req);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            wait_rise(s);
            #(half(s) / 2.0);
            if (clk_out !== 1'b1) bad++;
            wait_fall(s);
            #(half(s) / 2.0);
            if (clk_out !== 1'b0) bad++;
        end
        check(bad == 0, req, "output follows selected clock (mismatched samples)", bad, 0);
    endtask

    task automatic check_stays_low(input int ns, input string req);
        int highs = 0;
        for (int i = 0; i < ns; i++) begin
            #1;
            if (clk_out !== 1'b0) highs++;
        end
        check(highs == 0, req, "output held low (high samples)", highs, 0);
    endtask

    // release reset in the low phase of source s and count its falling edges
    // until the output first rises
    task automatic check_release(input int s);
        int n_rel;
        wait_fall(s);
        #(half(s) / 2.0);
        n_rel = falls(s);
        rst_n = 1'b1;
        @(posedge clk_out);
        #0.1;
        check((falls(s) - n_rel) inside {[2:3]}, "R7", "falling edges before first output pulse",
              falls(s) - n_rel, 2);
        check(clk_of(s) == 1'b1, "R7", "first output rise on source rising edge",
              int'(clk_of(s)), 1);
    endtask

    task automatic check_switch(input int old_s);
        int new_s = 1 - old_s;
        int n_sel;
        int n_park_old = 0;
        int n_park_new = 0;
        wait_fall(old_s);
        #(half(old_s) / 2.0);
        n_sel = falls(old_s);
        sel = (new_s == 1);
        for (int i = 1; i <= 6; i++) begin
            wait_rise(old_s);
            #(half(old_s) / 2.0);
            if (clk_out !== 1'b1) break;
            wait_fall(old_s);
            n_park_old = falls(old_s);
            n_park_new = falls(new_s);
        end
        check((n_park_old - n_sel) inside {[2:3]}, "R2", "old falling edges before park",
              n_park_old - n_sel, 2);
        @(posedge clk_out);
        #0.1;
        check((falls(new_s) - n_park_new) inside {[2:3]}, "R3", "new falling edges while parked",
              falls(new_s) - n_park_new, 2);
        check(clk_of(new_s) == 1'b1, "R3", "restart on new clock rising edge",
              int'(clk_of(new_s)), 1);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge ref_clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int highs;
        // R7: output low during reset
        #0.5 rst_n = 1'b0;
        highs = 0;
        for (int i = 0; i < 40; i++) begin
            #3;
            if (clk_out !== 1'b0) highs++;
        end
        check(highs == 0, "R7", "output low in reset (high samples)", highs, 0);
        check_release(0);
        mon_arm = 1'b1;
        settle();

        // R1: table of select levels and clock ratios
        for (int r = 0; r < NROWS; r++) begin
            h0 = real'(VEC[r][1]);
            h1 = real'(VEC[r][2]);
            #100;
            sel = VEC[r][0][0];
            settle();
            check_follow(VEC[r][0], VEC[r][3], "R1");
        end

        // R2 R3: timed handoffs in both directions
        h0 = 5.0;
        h1 = 7.0;
        settle();
        check_switch(1);
        settle();
        check_switch(0);
        settle();
        check_switch(1);
        settle();

        // R5: new clock absent
        wait_fall(1);
        run1 = 1'b0;
        #400;
        wait_fall(0);
        #2.5;
        sel = 1'b1;
        #100;
        check_stays_low(600, "R5");
        run1 = 1'b1;
        settle();
        check_follow(1, 20, "R5");

        // R6: old clock stops while selected
        wait_fall(1);
        run1 = 1'b0;
        #20;
        sel = 1'b0;
        check_stays_low(150, "R6");
        #1000;
        check_follow(0, 20, "R6");
        run1 = 1'b1;
        #300;
        sel = 1'b1;
        settle();
        check_follow(1, 20, "R6");

        // R7: reset during operation
        wait_rise(1);
        #1;
        rst_n = 1'b0;
        #0.5;
        check(clk_out == 1'b0, "R7", "output low at reset assertion", int'(clk_out), 0);
        #60;
        check_release(1);
        settle();
        check_follow(1, 10, "R7");

        // R4: no narrow phase anywhere in the run (shorter half period is 4 ns)
        check(min_w >= 3.9, "R4", "shortest output phase in ps", int'(min_w * 1000.0), 4000);

        finish_run();
    end

endmodule